// File: doc/BRIEF.md
# System MMU Control and Fault Register Block

This block is the software-visible control register set for a system MMU. Software reaches it through a simple word-wide register bus with a write strobe and a combinational read path. Toward the translation datapath it drives a translation-enable level, a block request, the page-table base and a QoS field. It takes back an idle indication from the datapath and a stream of fault events.

Control is written as small encoded words rather than single flags. The datapath is asked to block, and a status bit confirms that the blocked state has been reached once the datapath reports idle. Faults are logged separately for the read channel and the write channel. Each channel keeps the first fault it sees, together with a transaction-info word, until software clears the matching interrupt bit. A level interrupt is raised while either channel holds a fault.

Top module: `mmu_ctl_regs`

## Requirements
- R1: After reset the control, config, status, page-table base and interrupt status registers read 0, and `xlat_en`, `blk_req` and `irq` are low.
- R2: A write to offset 0x000 stores bits [2:0]. From the next cycle 0x5 gives `xlat_en`=1 and `blk_req`=0, 0x7 gives both 1, 0x3 gives `xlat_en`=0 and `blk_req`=1, and 0x0 gives both 0. The stored code reads back at 0x000.
- R3: Status (offset 0x008) bit 0 becomes 1 one cycle after `blk_req` and `dp_idle` are both high. It stays 0 while `dp_idle` is low.
- R4: Writing 0x5 to control while blocked drops `blk_req` on the next cycle and clears status bit 0 one cycle later. It keeps `xlat_en` high.
- R5: Config (offset 0x004) keeps only the written bits under mask 0x301F1F8C, and other bits read 0. `qos` outputs config bits [10:7].
- R6: Page-table base (offset 0x00C) is a full 32-bit read/write register driven on `pt_base`.
- R7: Version (offset 0x034) reads {major[3:0], minor[6:0], revision[3:0]} in bits [31:17] and zeros below, from the parameters.
- R8: A read-channel fault (`flt_write`=0) stores its address at 0x070 and its info word at 0x078. The info word holds bit 20 = 0, bits [18:16] = fault kind (0 walk error, 1 page fault, 2 multi-hit, 3 access, 4 security) and bits [15:0] = id. The fault sets interrupt status (offset 0x060) bit 0.
- R9: A write-channel fault (`flt_write`=1) stores its address at 0x080 and its info word at 0x088 with bit 20 = 1, and sets interrupt status bit 1.
- R10: While a channel's interrupt bit is set, later faults on that channel leave its captured address and info unchanged.
- R11: Writing 1 to bit n of offset 0x064 clears interrupt status bit n, and a 0 bit has no effect. A fault arriving in the same cycle as its clear is captured and leaves the bit set.
- R12: `irq` is high exactly while any interrupt status bit is set.
- R13: Unmapped offsets and offset 0x064 read 0. Writes to version, status and interrupt status change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| xlat_en | output | 1 | Translation enable to datapath |
| blk_req | output | 1 | Block request to datapath |
| pt_base | output | 32 | Page-table base |
| qos | output | 4 | QoS field from config |
| irq | output | 1 | Fault interrupt level |
| dp_idle | input | 1 | Datapath drained/idle |
| flt_valid | input | 1 | Fault event strobe |
| flt_write | input | 1 | Fault channel: 0 read, 1 write |
| flt_addr | input | AW (32) | Faulting address |
| flt_kind | input | 3 | Fault kind code |
| flt_id | input | 16 | Transaction id |

## Verification
A wrong block-handshake state shows at status bit 0. It would read 1 in the cycle before idle and request coincide, or stay high a cycle too long after release, and the bench samples each of those cycles. A fault log that overwrites, or fails to hold, shows as a changed captured address on the very next register read after a second fault. A lost or stray clear shows at once on `irq` and on the interrupt status word. Control decoding errors appear on `xlat_en` and `blk_req` in the cycle after the write.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

    localparam int OFFW = 12;
    localparam int DW   = 32;
    localparam int IDW  = 16;

    localparam logic [OFFW-1:0] OFF_CTRL   = 12'h000;
    localparam logic [OFFW-1:0] OFF_CFG    = 12'h004;
    localparam logic [OFFW-1:0] OFF_STAT   = 12'h008;
    localparam logic [OFFW-1:0] OFF_PTB    = 12'h00C;
    localparam logic [OFFW-1:0] OFF_VER    = 12'h034;
    localparam logic [OFFW-1:0] OFF_IPEND  = 12'h060;
    localparam logic [OFFW-1:0] OFF_ICLR   = 12'h064;
    localparam logic [OFFW-1:0] OFF_RFADDR = 12'h070;
    localparam logic [OFFW-1:0] OFF_RFINFO = 12'h078;
    localparam logic [OFFW-1:0] OFF_WFADDR = 12'h080;
    localparam logic [OFFW-1:0] OFF_WFINFO = 12'h088;

    localparam logic [DW-1:0] CFG_KEEP = 32'h301F_1F8C;
    localparam int QOS_LSB = 7;
    localparam int QOS_W   = 4;
    localparam int NCH     = 2;

    typedef enum logic [2:0] {
        FK_WALK   = 3'd0,
        FK_PAGE   = 3'd1,
        FK_MULTI  = 3'd2,
        FK_ACCESS = 3'd3,
        FK_SECURE = 3'd4
    } flt_kind_e;

    typedef struct packed {
        logic ctrl;
        logic cfg;
        logic stat;
        logic ptb;
        logic ver;
        logic ipend;
        logic iclr;
        logic rfaddr;
        logic rfinfo;
        logic wfaddr;
        logic wfinfo;
    } reg_sel_t;

    function automatic logic [DW-1:0] pack_info(input logic dir,
                                                 input logic [2:0] kind,
                                                 input logic [IDW-1:0] id);
        logic [DW-1:0] w;
        w        = '0;
        w[20]    = dir;
        w[18:16] = kind;
        w[15:0]  = id;
        return w;
    endfunction

    function automatic logic [DW-1:0] ver_word(input int maj, input int mnr, input int rev);
        logic [14:0] f;
        f = {maj[3:0], mnr[6:0], rev[3:0]};
        return {f, 17'd0};
    endfunction

endpackage

// File: rtl/mmu_ctl_decode.sv
module mmu_ctl_decode
    import mmu_ctl_pkg::*;
(
    input  logic [OFFW-1:0] offset,
    output reg_sel_t        sel
);
    always_comb begin
        sel = '0;
        case (offset)
            OFF_CTRL:   sel.ctrl   = 1'b1;
            OFF_CFG:    sel.cfg    = 1'b1;
            OFF_STAT:   sel.stat   = 1'b1;
            OFF_PTB:    sel.ptb    = 1'b1;
            OFF_VER:    sel.ver    = 1'b1;
            OFF_IPEND:  sel.ipend  = 1'b1;
            OFF_ICLR:   sel.iclr   = 1'b1;
            OFF_RFADDR: sel.rfaddr = 1'b1;
            OFF_RFINFO: sel.rfinfo = 1'b1;
            OFF_WFADDR: sel.wfaddr = 1'b1;
            OFF_WFINFO: sel.wfinfo = 1'b1;
            default:    sel        = '0;
        endcase
    end
endmodule

// File: rtl/mmu_ctl_block.sv
module mmu_ctl_block (
    input  logic clk,
    input  logic rst,
    input  logic blk_req,
    input  logic dp_idle,
    output logic blocked
);
    // Sticky once reached; released only when the request drops.
    always_ff @(posedge clk) begin
        if (rst)
            blocked <= 1'b0;
        else if (!blk_req)
            blocked <= 1'b0;
        else if (dp_idle)
            blocked <= 1'b1;
    end
endmodule

// File: rtl/mmu_ctl_fault_log.sv
module mmu_ctl_fault_log
    import mmu_ctl_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          clr,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] info_in,
    output logic          pending,
    output logic [AW-1:0] cap_addr,
    output logic [DW-1:0] cap_info
);
    logic take;
    assign take = hit && (!pending || clr);

    always_ff @(posedge clk) begin
        if (rst) begin
            pending  <= 1'b0;
            cap_addr <= '0;
            cap_info <= '0;
        end else if (take) begin
            pending  <= 1'b1;
            cap_addr <= addr_in;
            cap_info <= info_in;
        end else if (clr) begin
            pending  <= 1'b0;
        end
    end
endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
    import mmu_ctl_pkg::*;
#(
    parameter int AW      = 32,
    parameter int VER_MAJ = 7,
    parameter int VER_MIN = 1,
    parameter int VER_REV = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [OFFW-1:0]  reg_addr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    output logic             xlat_en,
    output logic             blk_req,
    output logic [DW-1:0]    pt_base,
    output logic [QOS_W-1:0] qos,
    output logic             irq,
    input  logic             dp_idle,
    input  logic             flt_valid,
    input  logic             flt_write,
    input  logic [AW-1:0]    flt_addr,
    input  logic [2:0]       flt_kind,
    input  logic [IDW-1:0]   flt_id
);
    localparam logic [DW-1:0] VER_WORD = ver_word(VER_MAJ, VER_MIN, VER_REV);

    reg_sel_t       sel;
    logic [2:0]     ctrl_q;
    logic [DW-1:0]  cfg_q;
    logic [DW-1:0]  ptb_q;
    logic           blocked;
    logic [NCH-1:0] pend;
    logic [AW-1:0]  cap_a [NCH];
    logic [DW-1:0]  cap_i [NCH];
    logic [AW-1:0]  rd_cap_addr;

    mmu_ctl_decode u_dec (
        .offset (reg_addr),
        .sel    (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            ptb_q  <= '0;
        end else if (reg_we) begin
            if (sel.ctrl) ctrl_q <= reg_wdata[2:0];
            if (sel.cfg)  cfg_q  <= reg_wdata & CFG_KEEP;
            if (sel.ptb)  ptb_q  <= reg_wdata;
        end
    end

    // Code bit 2 carries enable, bit 1 carries the block request.
    assign xlat_en = ctrl_q[2];
    assign blk_req = ctrl_q[1];
    assign pt_base = ptb_q;
    assign qos     = cfg_q[QOS_LSB +: QOS_W];

    mmu_ctl_block u_blk (
        .clk     (clk),
        .rst     (rst),
        .blk_req (blk_req),
        .dp_idle (dp_idle),
        .blocked (blocked)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam logic DIR = (ch == 1);
        logic hit_c, clr_c;
        assign hit_c = flt_valid && (flt_write == DIR);
        assign clr_c = reg_we && sel.iclr && reg_wdata[ch];
        mmu_ctl_fault_log #(.AW(AW)) u_log (
            .clk      (clk),
            .rst      (rst),
            .hit      (hit_c),
            .clr      (clr_c),
            .addr_in  (flt_addr),
            .info_in  (pack_info(DIR, flt_kind, flt_id)),
            .pending  (pend[ch]),
            .cap_addr (cap_a[ch]),
            .cap_info (cap_i[ch])
        );
    end

    assign rd_cap_addr = cap_a[0];
    assign irq         = |pend;

    always_comb begin
        reg_rdata = '0;
        unique case (1'b1)
            sel.ctrl:   reg_rdata = {{(DW-3){1'b0}}, ctrl_q};
            sel.cfg:    reg_rdata = cfg_q;
            sel.stat:   reg_rdata = {{(DW-1){1'b0}}, blocked};
            sel.ptb:    reg_rdata = ptb_q;
            sel.ver:    reg_rdata = VER_WORD;
            sel.ipend:  reg_rdata = {{(DW-NCH){1'b0}}, pend};
            sel.rfaddr: reg_rdata = DW'(cap_a[0]);
            sel.rfinfo: reg_rdata = cap_i[0];
            sel.wfaddr: reg_rdata = DW'(cap_a[1]);
            sel.wfinfo: reg_rdata = cap_i[1];
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mmu_ctl_checker.sv
module mmu_ctl_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          reg_we,
    input logic [11:0]   reg_addr,
    input logic [31:0]   reg_wdata,
    input logic          xlat_en,
    input logic          blk_req,
    input logic          dp_idle,
    input logic          blocked,
    input logic          flt_valid,
    input logic          flt_write,
    input logic [1:0]    int_pend,
    input logic [AW-1:0] rd_cap_addr
);
    a_r2_enable_code: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == 12'h000 && reg_wdata[2:0] == 3'h5) |=> (xlat_en && !blk_req));

    a_r3_blocked_needs_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(blocked) |-> $past(blk_req && dp_idle));

    a_r4_release: assert property (@(posedge clk) disable iff (rst)
        (blocked && !blk_req) |=> !blocked);

    a_r8_rd_sets: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && !flt_write) |=> int_pend[0]);

    a_r9_wr_sets: assert property (@(posedge clk) disable iff (rst)
        (flt_valid && flt_write) |=> int_pend[1]);

    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        (int_pend[0] && !(reg_we && reg_addr == 12'h064 && reg_wdata[0])) |=> $stable(rd_cap_addr));
endmodule

bind mmu_ctl_regs mmu_ctl_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .xlat_en     (xlat_en),
    .blk_req     (blk_req),
    .dp_idle     (dp_idle),
    .blocked     (blocked),
    .flt_valid   (flt_valid),
    .flt_write   (flt_write),
    .int_pend    (pend),
    .rd_cap_addr (rd_cap_addr)
);

// File: tb/tb_mmu_ctl_regs.sv
`timescale 1ns/1ps
module tb_mmu_ctl_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xlat_en, blk_req, irq;
    logic [31:0] pt_base;
    logic [3:0]  qos;
    logic        dp_idle = 1'b0;
    logic        flt_valid = 1'b0;
    logic        flt_write = 1'b0;
    logic [31:0] flt_addr = '0;
    logic [2:0]  flt_kind = '0;
    logic [15:0] flt_id = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    mmu_ctl_regs dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xlat_en(xlat_en),
        .blk_req(blk_req), .pt_base(pt_base), .qos(qos), .irq(irq),
        .dp_idle(dp_idle), .flt_valid(flt_valid), .flt_write(flt_write),
        .flt_addr(flt_addr), .flt_kind(flt_kind), .flt_id(flt_id)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic fault(input logic w, input logic [31:0] a, input logic [2:0] k, input logic [15:0] id);
        @(negedge clk);
        flt_valid = 1'b1; flt_write = w; flt_addr = a; flt_kind = k; flt_id = id;
        @(negedge clk);
        flt_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(12'h000, v); chk("R1 ctrl", v, 0);
        rd(12'h004, v); chk("R1 cfg", v, 0);
        rd(12'h008, v); chk("R1 status", v, 0);
        rd(12'h00C, v); chk("R1 ptbase", v, 0);
        rd(12'h060, v); chk("R1 intstat", v, 0);
        chk("R1 outs", {29'd0, xlat_en, blk_req, irq}, 0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(12'h000, 32'h5); chk("R2 code5", {30'd0, xlat_en, blk_req}, 2'b10);
        rd(12'h000, v);     chk("R2 readback", v, 5);
        wr(12'h000, 32'h7); chk("R2 code7", {30'd0, xlat_en, blk_req}, 2'b11);
        wr(12'h000, 32'h3); chk("R2 code3", {30'd0, xlat_en, blk_req}, 2'b01);
        wr(12'h000, 32'h0); chk("R2 code0", {30'd0, xlat_en, blk_req}, 2'b00);
    endtask

    task automatic t_block();
        logic [31:0] v;
        dp_idle = 1'b0;
        wr(12'h000, 32'h7);
        rd(12'h008, v); chk("R3 not idle", v, 0);
        @(negedge clk);
        rd(12'h008, v); chk("R3 still not idle", v, 0);
        dp_idle = 1'b1;
        rd(12'h008, v); chk("R3 before edge", v, 0);
        @(negedge clk);
        rd(12'h008, v); chk("R3 blocked", v, 1);
        wr(12'h000, 32'h5);
        chk("R4 release outs", {30'd0, xlat_en, blk_req}, 2'b10);
        rd(12'h008, v); chk("R4 status lag", v, 1);
        @(negedge clk);
        rd(12'h008, v); chk("R4 status cleared", v, 0);
        // request while idle already high, from disabled state
        wr(12'h000, 32'h3);
        rd(12'h008, v); chk("R3 one cycle lag", v, 0);
        @(negedge clk);
        rd(12'h008, v); chk("R3 blocked from off", v, 1);
        wr(12'h000, 32'h0);
        @(negedge clk);
        dp_idle = 1'b0;
    endtask

    task automatic t_cfg();
        logic [31:0] v;
        wr(12'h004, 32'hFFFF_FFFF);
        rd(12'h004, v); chk("R5 mask", v, 32'h301F_1F8C);
        chk("R5 qos all", {28'd0, qos}, 4'hF);
        wr(12'h004, 32'h0000_0380);
        rd(12'h004, v); chk("R5 value", v, 32'h380);
        chk("R5 qos 7", {28'd0, qos}, 4'h7);
    endtask

    task automatic t_ptb();
        logic [31:0] v;
        wr(12'h00C, 32'h1234_5678);
        rd(12'h00C, v); chk("R6 readback", v, 32'h1234_5678);
        chk("R6 port", pt_base, 32'h1234_5678);
    endtask

    task automatic t_ver();
        logic [31:0] v;
        rd(12'h034, v);
        chk("R7 version", v, ((32'd7 << 11) | (32'd1 << 4) | 32'd0) << 17);
    endtask

    task automatic t_faults();
        logic [31:0] v;
        fault(1'b0, 32'hA000_1000, 3'd1, 16'h0042);
        rd(12'h070, v); chk("R8 rd addr", v, 32'hA000_1000);
        rd(12'h078, v); chk("R8 rd info", v, 32'h0001_0042);
        rd(12'h060, v); chk("R8 intstat", v, 1);
        chk("R12 irq on", {31'd0, irq}, 1);
        fault(1'b0, 32'hDEAD_0000, 3'd3, 16'h0099);
        rd(12'h070, v); chk("R10 addr held", v, 32'hA000_1000);
        rd(12'h078, v); chk("R10 info held", v, 32'h0001_0042);
        fault(1'b1, 32'hB000_2000, 3'd4, 16'h0007);
        rd(12'h080, v); chk("R9 wr addr", v, 32'hB000_2000);
        rd(12'h088, v); chk("R9 wr info", v, 32'h0014_0007);
        rd(12'h060, v); chk("R9 intstat", v, 3);
    endtask

    task automatic t_clear();
        logic [31:0] v;
        wr(12'h064, 32'h0);
        rd(12'h060, v); chk("R11 zero no effect", v, 3);
        wr(12'h064, 32'h1);
        rd(12'h060, v); chk("R11 clear rd", v, 2);
        chk("R12 irq still", {31'd0, irq}, 1);
        wr(12'h064, 32'h2);
        rd(12'h060, v); chk("R11 clear wr", v, 0);
        chk("R12 irq off", {31'd0, irq}, 0);
        fault(1'b0, 32'h1111_0000, 3'd0, 16'h0001);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h064; reg_wdata = 32'h1;
        flt_valid = 1'b1; flt_write = 1'b0; flt_addr = 32'h2222_0000; flt_kind = 3'd2; flt_id = 16'h0005;
        @(negedge clk);
        reg_we = 1'b0; flt_valid = 1'b0;
        rd(12'h060, v); chk("R11 same-cycle pend", v, 1);
        rd(12'h070, v); chk("R11 same-cycle addr", v, 32'h2222_0000);
        rd(12'h078, v); chk("R11 same-cycle info", v, 32'h0002_0005);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(12'h100, v); chk("R13 unmapped", v, 0);
        rd(12'h064, v); chk("R13 clear reads 0", v, 0);
        wr(12'h034, 32'h0000_FFFF);
        rd(12'h034, v); chk("R13 version ro", v, ((32'd7 << 11) | (32'd1 << 4)) << 17);
        wr(12'h060, 32'h0);
        rd(12'h060, v); chk("R13 intstat ro", v, 1);
        wr(12'h008, 32'h1);
        rd(12'h008, v); chk("R13 status ro", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_block();
        t_cfg();
        t_ptb();
        t_ver();
        t_faults();
        t_clear();
        t_unmapped();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule